// File: doc/BRIEF.md
# Indexed Effective Address Generator

This block works out the operand address for an 8-bit processor with a 16-bit address bus. The instruction sequencer gives it an addressing-mode code, the one or two operand bytes already taken from the instruction stream, and the X and Y index registers. For branches it also gives the program counter and the branch decision. The generator then runs its own bus reads, one per clock. These reads fetch pointers from memory and make the throw-away accesses that the processor is known to perform. When it is finished it presents the 16-bit effective address with a one-cycle done strobe.

The block keeps the legacy behaviour on purpose. Zero-page pointers and zero-page indexing wrap within the first 256 bytes. The indirect jump takes its high pointer byte from inside the same page. Indexed modes put a discarded read on the bus at the address whose high byte has not yet been carried. Read-class operations make that discarded read only when the page changes, while write and read-modify-write operations always make it. Executing the instruction and moving its data are left to the surrounding core.

Top module: `ixaddr_gen`

## Requirements
- R1: A `start` pulse is accepted only while `busy` is low, and `start` has no effect while `busy` is high. Each accepted request ends with `done` high for exactly one cycle. That cycle comes one clock after the request's last bus access, or one clock after `start` when the mode makes no access. `ea` is valid in that cycle. The mode codes are 0 zero-page, 1 zero-page+X, 2 zero-page+Y, 3 absolute, 4 absolute+X, 5 absolute+Y, 6 indexed-indirect (X), 7 indirect-indexed (Y), 8 indirect jump and 9 relative branch; all other codes act as absolute.
- R2: Each bus access lasts one clock. In that clock `rd_en` is high and `rd_addr` holds the address, and `rd_data` is taken in the same clock. `rd_dummy` is high only together with `rd_en`, and only for accesses whose data is discarded.
- R3: Zero-page+X and zero-page+Y first make one dummy read at `{0x00, op_lo}`. The result is then `{0x00, (op_lo + index) mod 256}`. Every read these modes make is in page zero.
- R4: For absolute+X and absolute+Y with `wr_class` = 0, no access is made when `op_lo + index` stays below 256. When it reaches 256 or more, one dummy read is made at `{op_hi, (op_lo + index) mod 256}`. In both cases the result is the full 16-bit sum `{op_hi, op_lo} + index`.
- R5: With `wr_class` = 1, absolute+X, absolute+Y and indirect-indexed always make that uncarried dummy read, whether or not the page changes.
- R6: Indexed-indirect makes a dummy read at `{0x00, op_lo}`. Let p = `(op_lo + X) mod 256`. It then reads the pointer low byte at `{0x00, p}` and the high byte at `{0x00, (p + 1) mod 256}`. The result is that pointer.
- R7: Indirect-indexed reads the pointer at `{0x00, op_lo}` and `{0x00, (op_lo + 1) mod 256}`. The result is the pointer plus Y with a full 16-bit carry. The dummy-read rules of R4 and R5 apply, with the pointer as the base.
- R8: The indirect jump reads the pointer at `{op_hi, op_lo}` and then at `{op_hi, (op_lo + 1) mod 256}`, so the second read never leaves the page. The result is that pointer.
- R9: For a relative branch that is not taken, no access is made and the result is `pc`. A taken branch makes a dummy read at `pc`. If `pc + sign-extended op_lo` has a different high byte from `pc`, a second dummy read follows at `{pc[15:8], (pc[7:0] + op_lo) mod 256}`. The result is `pc + sign-extended op_lo`.
- R10: While reset is asserted, and until the first request, `busy`, `done` and `rd_en` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; its release is synchronised inside the block |
| start | input | 1 | Request pulse, taken only while idle |
| mode | input | 4 | Addressing-mode code (R1) |
| wr_class | input | 1 | 1 for write or read-modify-write operations, 0 for reads |
| br_taken | input | 1 | Branch decision, used in relative mode |
| op_lo | input | 8 | First operand byte (address low byte or branch offset) |
| op_hi | input | 8 | Second operand byte (address high byte) |
| idx_x | input | 8 | X index register |
| idx_y | input | 8 | Y index register |
| pc | input | 16 | Address of the next instruction, used in relative mode |
| rd_data | input | 8 | Read data, valid in the cycle of the access |
| rd_en | output | 1 | Bus read strobe |
| rd_addr | output | 16 | Bus read address |
| rd_dummy | output | 1 | The current read is discarded |
| busy | output | 1 | A request is in progress |
| done | output | 1 | One-cycle completion strobe |
| ea | output | 16 | Effective address, valid while done is high |

## Verification
Some properties are checked by assertions on every cycle:
- a dummy flag never appears without a read;
- done is a single-cycle pulse and is followed by idle;
- reads in the zero-page modes, and the pointer reads of indirect-indexed mode, stay in page zero;
- the two pointer reads of an indirect jump share a high byte and have consecutive low bytes;
- an indexed dummy read is followed at once by done, and for read-class operations the final high byte differs from the uncarried one;
- every read a relative branch makes is a dummy read.

Other behaviour can only be shown by the bench's scenarios against a memory model whose contents depend on both address bytes:
- the exact access counts and cycle latency;
- the values of the final addresses;
- where pointers wrap;
- that the indirect jump fails to carry into the next page;
- that backward branches produce the correct uncarried address;
- that a start during a request is ignored.

// File: rtl/ixaddr_pkg.sv
package ixaddr_pkg;

  localparam int AW = 16;
  localparam int DW = 8;
  localparam int MW = 4;

  typedef enum logic [MW-1:0] {
    M_ZP   = 4'd0,
    M_ZPX  = 4'd1,
    M_ZPY  = 4'd2,
    M_ABS  = 4'd3,
    M_ABSX = 4'd4,
    M_ABSY = 4'd5,
    M_IZX  = 4'd6,
    M_IZY  = 4'd7,
    M_IND  = 4'd8,
    M_REL  = 4'd9
  } mode_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_ZPDUM,
    S_PLO,
    S_PHI,
    S_FIX,
    S_BR1,
    S_BR2,
    S_DONE
  } state_e;

endpackage

// File: rtl/ixaddr_rst_sync.sv
module ixaddr_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = sync_q[STAGES-1];

endmodule

// File: rtl/ixaddr_math.sv
module ixaddr_math
  import ixaddr_pkg::*;
(
  input  logic [AW-1:0] base,
  input  logic [DW-1:0] idx,
  input  logic          zp_wrap,
  input  logic          sext,
  output logic [AW-1:0] ea_full,
  output logic [AW-1:0] partial,
  output logic          crossed
);

  localparam int HW = AW - DW;

  logic [DW-1:0] lo_sum;
  logic [AW-1:0] ext;
  logic [AW-1:0] full;

  always_comb begin
    lo_sum  = base[DW-1:0] + idx;
    ext     = sext ? {{HW{idx[DW-1]}}, idx} : {{HW{1'b0}}, idx};
    full    = base + ext;
    // zero-page indexing never carries out of page zero
    ea_full = zp_wrap ? {{HW{1'b0}}, lo_sum} : full;
    // low byte summed, high byte not yet corrected
    partial = {base[AW-1:DW], lo_sum};
    crossed = full[AW-1:DW] != base[AW-1:DW];
  end

endmodule

// File: rtl/ixaddr_seq.sv
module ixaddr_seq
  import ixaddr_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [MW-1:0] mode,
  input  logic          wr_class,
  input  logic          br_taken,
  input  logic [DW-1:0] op_lo,
  input  logic [DW-1:0] op_hi,
  input  logic [DW-1:0] idx_x,
  input  logic [DW-1:0] idx_y,
  input  logic [AW-1:0] pc,
  input  logic [DW-1:0] rd_data,
  input  logic [AW-1:0] partial,
  input  logic          crossed,
  output logic          rd_en,
  output logic [AW-1:0] rd_addr,
  output logic          rd_dummy,
  output logic          busy,
  output logic          done,
  output logic [AW-1:0] base_q,
  output logic [DW-1:0] idx_q,
  output logic [MW-1:0] mode_q,
  output logic          wr_q,
  output logic          zp_wrap,
  output logic          sext
);

  localparam int HW = AW - DW;

  state_e        st_q, st_d;
  logic [MW-1:0] mode_d;
  logic          wr_d;
  logic [AW-1:0] base_d, ptr_q, ptr_d, ptr_nx;
  logic [DW-1:0] idx_d, idx_sel;
  logic [DW:0]   in_carry, ptr_carry;

  always_comb begin
    idx_sel   = (mode_e'(mode) inside {M_ZPY, M_ABSY, M_IZY}) ? idx_y : idx_x;
    in_carry  = {1'b0, op_lo} + {1'b0, idx_sel};
    ptr_carry = {1'b0, base_q[DW-1:0]} + {1'b0, idx_q};
    // second pointer byte stays inside the pointer's page
    ptr_nx    = {ptr_q[AW-1:DW], ptr_q[DW-1:0] + 1'b1};
  end

  always_comb begin
    st_d     = st_q;
    mode_d   = mode_q;
    wr_d     = wr_q;
    base_d   = base_q;
    idx_d    = idx_q;
    ptr_d    = ptr_q;
    rd_en    = 1'b0;
    rd_addr  = '0;
    rd_dummy = 1'b0;
    unique case (st_q)
      S_IDLE: if (start) begin
        mode_d = mode;
        wr_d   = wr_class;
        unique case (mode_e'(mode))
          M_ZP: begin
            base_d = {{HW{1'b0}}, op_lo}; idx_d = '0; st_d = S_DONE;
          end
          M_ZPX, M_ZPY: begin
            base_d = {{HW{1'b0}}, op_lo}; idx_d = idx_sel; st_d = S_ZPDUM;
          end
          M_ABSX, M_ABSY: begin
            base_d = {op_hi, op_lo}; idx_d = idx_sel;
            st_d   = (wr_class || in_carry[DW]) ? S_FIX : S_DONE;
          end
          M_IZX: begin
            base_d = {{HW{1'b0}}, op_lo}; idx_d = idx_x; st_d = S_ZPDUM;
          end
          M_IZY: begin
            ptr_d = {{HW{1'b0}}, op_lo}; idx_d = idx_y; st_d = S_PLO;
          end
          M_IND: begin
            ptr_d = {op_hi, op_lo}; idx_d = '0; st_d = S_PLO;
          end
          M_REL: begin
            base_d = pc; idx_d = br_taken ? op_lo : '0;
            st_d   = br_taken ? S_BR1 : S_DONE;
          end
          default: begin
            base_d = {op_hi, op_lo}; idx_d = '0; st_d = S_DONE;
          end
        endcase
      end
      S_ZPDUM: begin
        rd_en = 1'b1; rd_dummy = 1'b1;
        rd_addr = {{HW{1'b0}}, base_q[DW-1:0]};
        if (mode_e'(mode_q) == M_IZX) begin
          ptr_d = {{HW{1'b0}}, base_q[DW-1:0] + idx_q};
          idx_d = '0;
          st_d  = S_PLO;
        end else begin
          st_d  = S_DONE;
        end
      end
      S_PLO: begin
        rd_en = 1'b1; rd_addr = ptr_q;
        base_d[DW-1:0] = rd_data;
        st_d = S_PHI;
      end
      S_PHI: begin
        rd_en = 1'b1; rd_addr = ptr_nx;
        base_d[AW-1:DW] = rd_data;
        if (mode_e'(mode_q) == M_IZY && (wr_q || ptr_carry[DW])) st_d = S_FIX;
        else                                                      st_d = S_DONE;
      end
      S_FIX: begin
        rd_en = 1'b1; rd_dummy = 1'b1; rd_addr = partial; st_d = S_DONE;
      end
      S_BR1: begin
        rd_en = 1'b1; rd_dummy = 1'b1; rd_addr = base_q;
        st_d = crossed ? S_BR2 : S_DONE;
      end
      S_BR2: begin
        rd_en = 1'b1; rd_dummy = 1'b1; rd_addr = partial; st_d = S_DONE;
      end
      S_DONE: st_d = S_IDLE;
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= S_IDLE;
      mode_q <= '0;
      wr_q   <= 1'b0;
      base_q <= '0;
      idx_q  <= '0;
      ptr_q  <= '0;
    end else begin
      st_q   <= st_d;
      mode_q <= mode_d;
      wr_q   <= wr_d;
      base_q <= base_d;
      idx_q  <= idx_d;
      ptr_q  <= ptr_d;
    end
  end

  assign busy    = st_q != S_IDLE;
  assign done    = st_q == S_DONE;
  assign zp_wrap = mode_e'(mode_q) inside {M_ZPX, M_ZPY};
  assign sext    = mode_e'(mode_q) == M_REL;

endmodule

// File: rtl/ixaddr_gen.sv
module ixaddr_gen
  import ixaddr_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [3:0]    mode,
  input  logic          wr_class,
  input  logic          br_taken,
  input  logic [7:0]    op_lo,
  input  logic [7:0]    op_hi,
  input  logic [7:0]    idx_x,
  input  logic [7:0]    idx_y,
  input  logic [15:0]   pc,
  input  logic [7:0]    rd_data,
  output logic          rd_en,
  output logic [15:0]   rd_addr,
  output logic          rd_dummy,
  output logic          busy,
  output logic          done,
  output logic [15:0]   ea
);

  logic          rst_n_i;
  logic [AW-1:0] base_q, partial, ea_full;
  logic [DW-1:0] idx_q;
  logic [MW-1:0] cur_mode;
  logic          cur_wr, zp_wrap, sext, crossed;

  ixaddr_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_i)
  );

  ixaddr_seq u_seq (
    .clk(clk), .rst_n(rst_n_i), .start(start), .mode(mode),
    .wr_class(wr_class), .br_taken(br_taken), .op_lo(op_lo), .op_hi(op_hi),
    .idx_x(idx_x), .idx_y(idx_y), .pc(pc), .rd_data(rd_data),
    .partial(partial), .crossed(crossed),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_dummy(rd_dummy),
    .busy(busy), .done(done), .base_q(base_q), .idx_q(idx_q),
    .mode_q(cur_mode), .wr_q(cur_wr), .zp_wrap(zp_wrap), .sext(sext)
  );

  ixaddr_math u_math (
    .base(base_q), .idx(idx_q), .zp_wrap(zp_wrap), .sext(sext),
    .ea_full(ea_full), .partial(partial), .crossed(crossed)
  );

  assign ea = ea_full;

endmodule

// File: rtl/ixaddr_gen_chk.sv
module ixaddr_gen_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        busy,
  input logic        done,
  input logic        rd_en,
  input logic        rd_dummy,
  input logic [15:0] rd_addr,
  input logic [15:0] ea,
  input logic [3:0]  cur_mode,
  input logic        cur_wr
);

  a_r2_dummy_is_read: assert property (@(posedge clk) disable iff (!rst_n)
    rd_dummy |-> rd_en);

  a_r1_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done && !busy);

  a_r10_quiet_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !rd_en && !done);

  a_r3_page_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && (cur_mode inside {4'd1, 4'd2, 4'd6} || (cur_mode == 4'd7 && !rd_dummy)))
      |-> rd_addr[15:8] == 8'h00);

  a_r4_fix_then_done: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_dummy && cur_mode inside {4'd4, 4'd5, 4'd7}) |=> done);

  a_r4_read_fix_only_on_cross: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_dummy && cur_mode inside {4'd4, 4'd5, 4'd7} && !cur_wr)
      |=> ea[15:8] != $past(rd_addr[15:8]));

  a_r8_same_page: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && cur_mode == 4'd8 && $past(rd_en))
      |-> rd_addr[15:8] == $past(rd_addr[15:8]) &&
          rd_addr[7:0] == $past(rd_addr[7:0]) + 8'd1);

  a_r9_branch_dummy: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && cur_mode == 4'd9) |-> rd_dummy);

endmodule

bind ixaddr_gen ixaddr_gen_chk u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .rd_en(rd_en),
  .rd_dummy(rd_dummy), .rd_addr(rd_addr), .ea(ea),
  .cur_mode(cur_mode), .cur_wr(cur_wr)
);

// File: tb/ixaddr_gen_test.sv
module ixaddr_gen_test;

  logic        clk;
  logic        rst_n;
  logic        start, wr_class, br_taken;
  logic [3:0]  mode;
  logic [7:0]  op_lo, op_hi, idx_x, idx_y, rd_data;
  logic [15:0] pc, rd_addr, ea;
  logic        rd_en, rd_dummy, busy, done;

  int checks = 0;
  int errors = 0;

  // trace of the last request
  int          tr_n, tr_nd, tr_cyc;
  logic [15:0] tr_ea;
  logic [15:0] tr_addr [8];
  logic        tr_dum  [8];

  ixaddr_gen uut (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .wr_class(wr_class),
    .br_taken(br_taken), .op_lo(op_lo), .op_hi(op_hi), .idx_x(idx_x),
    .idx_y(idx_y), .pc(pc), .rd_data(rd_data), .rd_en(rd_en),
    .rd_addr(rd_addr), .rd_dummy(rd_dummy), .busy(busy), .done(done), .ea(ea)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // memory model: contents depend on both address bytes
  function automatic logic [7:0] md(input logic [15:0] a);
    return a[7:0] + a[15:8] + 8'd1;
  endfunction
  assign rd_data = md(rd_addr);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run_op(input logic [3:0] m, input logic w, input logic tk,
                        input logic [7:0] lo, input logic [7:0] hi,
                        input logic [7:0] x, input logic [7:0] y,
                        input logic [15:0] p, input logic poke);
    @(negedge clk);
    start = 1'b1; mode = m; wr_class = w; br_taken = tk;
    op_lo = lo; op_hi = hi; idx_x = x; idx_y = y; pc = p;
    tr_n = 0; tr_nd = 0; tr_cyc = 0; tr_ea = '0;
    for (int k = 0; k < 8; k++) begin tr_addr[k] = '0; tr_dum[k] = 1'b0; end
    @(posedge clk);
    for (int c = 0; c < 20; c++) begin
      @(negedge clk);
      tr_cyc++;
      start = (poke && tr_cyc == 1);
      if (poke && tr_cyc == 1) mode = 4'd0;
      if (rd_en) begin
        if (tr_n < 8) begin tr_addr[tr_n] = rd_addr; tr_dum[tr_n] = rd_dummy; end
        tr_n++;
        if (rd_dummy) tr_nd++;
      end
      if (done) begin tr_ea = ea; break; end
    end
    start = 1'b0;
  endtask

  function automatic string tag(input logic [3:0] m, input logic w);
    case (m)
      4'd1, 4'd2: return "R3";
      4'd4, 4'd5: return w ? "R5" : "R4";
      4'd6:       return "R6";
      4'd7:       return "R7";
      4'd8:       return "R8";
      4'd9:       return "R9";
      default:    return "R1";
    endcase
  endfunction

  // {mode, wr, taken, lo, hi, x, y, pc, accesses, dummies, ea}
  localparam int NV = 18;
  localparam logic [75:0] TBL [NV] = '{
    {4'd0,1'b0,1'b0,8'h34,8'h00,8'h00,8'h00,16'h0000,3'd0,3'd0,16'h0034},
    {4'd1,1'b0,1'b0,8'hF0,8'h00,8'h20,8'h00,16'h0000,3'd1,3'd1,16'h0010},
    {4'd2,1'b0,1'b0,8'h10,8'h00,8'h00,8'h05,16'h0000,3'd1,3'd1,16'h0015},
    {4'd3,1'b0,1'b0,8'h34,8'h12,8'h00,8'h00,16'h0000,3'd0,3'd0,16'h1234},
    {4'd4,1'b0,1'b0,8'h34,8'h12,8'h10,8'h00,16'h0000,3'd0,3'd0,16'h1244},
    {4'd4,1'b0,1'b0,8'hF0,8'h12,8'h20,8'h00,16'h0000,3'd1,3'd1,16'h1310},
    {4'd5,1'b1,1'b0,8'h34,8'h12,8'h00,8'h01,16'h0000,3'd1,3'd1,16'h1235},
    {4'd6,1'b0,1'b0,8'h80,8'h00,8'h05,8'h00,16'h0000,3'd3,3'd1,16'h8786},
    {4'd6,1'b0,1'b0,8'hF0,8'h00,8'h0F,8'h00,16'h0000,3'd3,3'd1,16'h0100},
    {4'd7,1'b0,1'b0,8'h40,8'h00,8'h00,8'h10,16'h0000,3'd2,3'd0,16'h4251},
    {4'd7,1'b0,1'b0,8'h40,8'h00,8'h00,8'hC0,16'h0000,3'd3,3'd1,16'h4301},
    {4'd7,1'b1,1'b0,8'hFF,8'h00,8'h00,8'h00,16'h0000,3'd3,3'd1,16'h0100},
    {4'd8,1'b0,1'b0,8'hFF,8'h30,8'h00,8'h00,16'h0000,3'd2,3'd0,16'h3130},
    {4'd8,1'b0,1'b0,8'h10,8'h30,8'h00,8'h00,16'h0000,3'd2,3'd0,16'h4241},
    {4'd9,1'b0,1'b0,8'h10,8'h00,8'h00,8'h00,16'h1000,3'd0,3'd0,16'h1000},
    {4'd9,1'b0,1'b1,8'h10,8'h00,8'h00,8'h00,16'h1000,3'd1,3'd1,16'h1010},
    {4'd9,1'b0,1'b1,8'h20,8'h00,8'h00,8'h00,16'h10F0,3'd2,3'd2,16'h1110},
    {4'd9,1'b0,1'b1,8'hF0,8'h00,8'h00,8'h00,16'h1005,3'd2,3'd2,16'h0FF5}
  };

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; mode = '0; wr_class = 1'b0; br_taken = 1'b0;
    op_lo = '0; op_hi = '0; idx_x = '0; idx_y = '0; pc = '0;
    repeat (3) @(negedge clk);
    // R10: reset state
    check("R10 busy", busy, 0);
    check("R10 done", done, 0);
    check("R10 rd_en", rd_en, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R10 idle after release", {busy, done, rd_en}, 0);

    for (int i = 0; i < NV; i++) begin
      logic [75:0] e;
      string t;
      e = TBL[i];
      t = tag(e[75:72], e[71]);
      run_op(e[75:72], e[71], e[70], e[69:62], e[61:54], e[53:46], e[45:38],
             e[37:22], 1'b0);
      check({t, " accesses"}, tr_n, e[21:19]);
      check({t, " dummies"}, tr_nd, e[18:16]);
      check({t, " ea"}, tr_ea, e[15:0]);
      check("R1 latency", tr_cyc, e[21:19] + 1);
    end

    // R3: dummy at unindexed page-zero address
    run_op(4'd1, 1'b0, 1'b0, 8'hF0, 8'h77, 8'h20, 8'h00, 16'h0, 1'b0);
    check("R3 dummy addr", tr_addr[0], 16'h00F0);
    check("R2 dummy flag", tr_dum[0], 1);

    // R6: pointer wraps from 0xFF to 0x00
    run_op(4'd6, 1'b0, 1'b0, 8'hF0, 8'h00, 8'h0F, 8'h00, 16'h0, 1'b0);
    check("R6 ptr lo addr", tr_addr[1], 16'h00FF);
    check("R6 ptr hi addr", tr_addr[2], 16'h0000);
    check("R2 ptr not dummy", tr_dum[1], 0);

    // R8: high pointer byte from start of same page
    run_op(4'd8, 1'b0, 1'b0, 8'hFF, 8'h30, 8'h00, 8'h00, 16'h0, 1'b0);
    check("R8 first addr", tr_addr[0], 16'h30FF);
    check("R8 second addr", tr_addr[1], 16'h3000);

    // R7: uncarried dummy on page cross
    run_op(4'd7, 1'b0, 1'b0, 8'h40, 8'h00, 8'h00, 8'hC0, 16'h0, 1'b0);
    check("R7 pointer addr", tr_addr[1], 16'h0041);
    check("R7 fix addr", tr_addr[2], 16'h4201);

    // R4: uncarried dummy for absolute+X
    run_op(4'd4, 1'b0, 1'b0, 8'hF0, 8'h12, 8'h20, 8'h00, 16'h0, 1'b0);
    check("R4 fix addr", tr_addr[0], 16'h1210);

    // R9: backward branch crossing a page
    run_op(4'd9, 1'b0, 1'b1, 8'hF0, 8'h00, 8'h00, 8'h00, 16'h1005, 1'b0);
    check("R9 first dummy", tr_addr[0], 16'h1005);
    check("R9 second dummy", tr_addr[1], 16'h10F5);

    // R1: start during a request is ignored
    run_op(4'd6, 1'b0, 1'b0, 8'h80, 8'h00, 8'h05, 8'h00, 16'h0, 1'b1);
    check("R1 poke ea", tr_ea, 16'h8786);
    check("R1 poke accesses", tr_n, 3);
    @(negedge clk);
    check("R1 idle after poke", {busy, rd_en}, 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule